// File: doc/BRIEF.md
# Single-channel DMA transfer engine

This block is one channel of a direct memory access engine. It copies data items, one at a time, between two address spaces, called the peripheral side and the memory side. Each item is fetched through a read request/response port and stored through a write port. Software sets the channel up through a small register file: a control word, an item count and one base address for each side. Software then sets the enable bit. A direction bit decides which side is read and which side is written.

Two things can pace a transfer. In request-paced mode, each hardware request moves one item, and the channel acknowledges it. In memory-to-memory mode, the channel starts items by itself until the count runs out. In circular mode, the count and both addresses reload when the block ends, so the transfer keeps running. The channel raises a transfer-complete flag at the end of each block. Setting circular and memory-to-memory together is refused and raises a configuration-error flag.

All three bus channels use valid/ready handshakes. A valid signal, once raised, stays high with its payload unchanged until ready is seen at a clock edge. The channel has at most one item in flight. It raises the read-response ready only while it waits for read data. A slave can stall the channel for any number of cycles by holding ready low, and nothing is lost.

Top module: `dma_chan_engine`

## Requirements
- R1: When the direction bit is 1, reads use the memory-side address, size and increment settings, and writes use the peripheral-side settings.
- R2: When the direction bit is 0, reads use the peripheral-side settings, and writes use the memory-side settings.
- R3: Size codes are 00 for 8-bit, 01 for 16-bit, 10 for 32-bit, and 11 behaves as 32-bit. After every item, a side whose increment bit is set advances its address by the item size in bytes. A side whose increment bit is clear keeps its address.
- R4: Items are right-aligned on the 32-bit data buses. The write data is the read data cut to the source size and then cut to the destination size, with the upper bits zero.
- R5: In request-paced mode, nothing moves while the request is low. A request that is held high starts one item. `dreq_ack` pulses in the cycle in which that item's write is accepted. A request still high in the cycle after the acknowledge starts another item.
- R6: In memory-to-memory mode, the channel starts items without a request until the count reaches zero. It then sets the complete flag and clears its enable bit.
- R7: In circular mode, the last item of a block reloads the count and both addresses from their programmed values, sets the complete flag, and leaves the channel enabled.
- R8: Setting the enable bit while circular and memory-to-memory are both set leaves the channel disabled, starts no bus activity, and sets the configuration-error flag.
- R9: A channel enabled with a count of zero issues no read request.
- R10: Clearing the enable bit during an item lets that item complete. No further item starts.
- R11: While the channel is enabled or has an item in flight, writes to the count, to the address registers and to the control fields are ignored. A control write with enable at 0 still disables the channel. Control bit 31 written as 1 clears the complete flag, and bit 30 written as 1 clears the error flag, at any time. A flag set in the same cycle wins over its clear.
- R12: `rd_req_valid` and `wr_valid`, with their address, size and data, stay stable until accepted. `rd_resp_ready` is high only while read data is awaited.
- R13: Register index 0 is the control word: bit 0 enable, bit 1 direction, bit 2 circular, bit 3 memory-to-memory, bits 5:4 peripheral size, bits 7:6 memory size, bit 8 peripheral increment, bit 9 memory increment. Index 1 is the count, index 2 is the peripheral base and index 3 is the memory base. A newly enabled channel loads its remaining count and current addresses from these. After reset, every register, flag and output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| dreq | input | 1 | Hardware transfer request (level) |
| dreq_ack | output | 1 | One-cycle acknowledge of a request-paced item |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Read address |
| rd_req_size | output | 2 | Read item size code |
| rd_resp_valid | input | 1 | Read data valid |
| rd_resp_ready | output | 1 | Channel waits for read data |
| rd_resp_data | input | 32 | Read data, right-aligned |
| wr_valid | output | 1 | Write valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | ADDR_W | Write address |
| wr_size | output | 2 | Write item size code |
| wr_data | output | 32 | Write data, right-aligned |
| ch_enabled | output | 1 | Enable bit of the control word |
| tc_flag | output | 1 | Transfer-complete flag |
| cfg_err | output | 1 | Configuration-error flag |
| remaining | output | CNT_W | Items left in the current block |

## Verification
The channel raises `rd_req_valid` one cycle after the edge that enables it in memory-to-memory mode. In request-paced mode, it raises `rd_req_valid` one cycle after an edge that sees the request. Flags, remaining count and enable change at the edge that accepts the write. A register write shows at the edge that takes the strobe. `dreq_ack` is combinational with the write handshake.

The bench applies each stimulus at a falling edge and reads the outputs one time unit later. It then advances its behavioural model by exactly the handshakes and writes that the next rising edge will take. As a result, every clock compares outputs with a model that has absorbed precisely the edges the design has seen. Stall patterns on all three ready/valid inputs move these events around without changing the expected sequence of addresses and data.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SZ_8   = 2'b00,
    SZ_16  = 2'b01,
    SZ_32  = 2'b10,
    SZ_RSV = 2'b11
  } item_size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_RESP,
    ST_WR
  } xfer_state_e;

  typedef struct packed {
    logic       minc;
    logic       pinc;
    item_size_e msize;
    item_size_e psize;
    logic       m2m;
    logic       circ;
    logic       dir;
  } chan_cfg_t;

  localparam int SIDE_PER = 0;
  localparam int SIDE_MEM = 1;
  localparam int N_SIDES  = 2;

  localparam logic [1:0] REG_CTRL  = 2'd0;
  localparam logic [1:0] REG_COUNT = 2'd1;
  localparam logic [1:0] REG_PADDR = 2'd2;
  localparam logic [1:0] REG_MADDR = 2'd3;

  localparam int CB_EN      = 0;
  localparam int CB_DIR     = 1;
  localparam int CB_CIRC    = 2;
  localparam int CB_M2M     = 3;
  localparam int CB_PSIZE   = 4;
  localparam int CB_MSIZE   = 6;
  localparam int CB_PINC    = 8;
  localparam int CB_MINC    = 9;
  localparam int CB_CLR_ERR = 30;
  localparam int CB_CLR_TC  = 31;

  function automatic logic [2:0] size_bytes(item_size_e s);
    case (s)
      SZ_8:    return 3'd1;
      SZ_16:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] size_mask(logic [DATA_W-1:0] d, item_size_e s);
    case (s)
      SZ_8:    return {{(DATA_W-8){1'b0}}, d[7:0]};
      SZ_16:   return {{(DATA_W-16){1'b0}}, d[15:0]};
      default: return d;
    endcase
  endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              busy,
  input  logic              tc_set,
  input  logic              blk_end,
  output chan_cfg_t         cfg,
  output logic              enable,
  output logic              start,
  output logic [CNT_W-1:0]  base_cnt,
  output logic [ADDR_W-1:0] base_paddr,
  output logic [ADDR_W-1:0] base_maddr,
  output logic              tc_flag,
  output logic              cfg_err
);

  logic ctrl_wr, locked, bad_combo, bad_try;
  logic unused_wbits;

  assign ctrl_wr   = reg_we && (reg_addr == REG_CTRL);
  assign locked    = enable || busy;
  assign bad_combo = reg_wdata[CB_CIRC] && reg_wdata[CB_M2M];
  assign start     = ctrl_wr && !locked && reg_wdata[CB_EN] && !bad_combo;
  assign bad_try   = ctrl_wr && !locked && reg_wdata[CB_EN] && bad_combo;
  assign unused_wbits = ^reg_wdata[29:10];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg        <= '0;
      enable     <= 1'b0;
      base_cnt   <= '0;
      base_paddr <= '0;
      base_maddr <= '0;
      tc_flag    <= 1'b0;
      cfg_err    <= 1'b0;
    end else begin
      if (ctrl_wr && !locked) begin
        cfg.dir   <= reg_wdata[CB_DIR];
        cfg.circ  <= reg_wdata[CB_CIRC];
        cfg.m2m   <= reg_wdata[CB_M2M];
        cfg.psize <= item_size_e'(reg_wdata[CB_PSIZE+:2]);
        cfg.msize <= item_size_e'(reg_wdata[CB_MSIZE+:2]);
        cfg.pinc  <= reg_wdata[CB_PINC];
        cfg.minc  <= reg_wdata[CB_MINC];
      end
      if (blk_end) begin
        enable <= 1'b0;
      end else if (ctrl_wr) begin
        if (!locked)                enable <= start;
        else if (!reg_wdata[CB_EN]) enable <= 1'b0;
      end
      if (reg_we && !locked) begin
        if (reg_addr == REG_COUNT) base_cnt   <= reg_wdata[CNT_W-1:0];
        if (reg_addr == REG_PADDR) base_paddr <= reg_wdata[ADDR_W-1:0];
        if (reg_addr == REG_MADDR) base_maddr <= reg_wdata[ADDR_W-1:0];
      end
      if (tc_set)                                tc_flag <= 1'b1;
      else if (ctrl_wr && reg_wdata[CB_CLR_TC])  tc_flag <= 1'b0;
      if (bad_try)                               cfg_err <= 1'b1;
      else if (ctrl_wr && reg_wdata[CB_CLR_ERR]) cfg_err <= 1'b0;
    end
  end

  assert_bad_combo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_try |=> (cfg_err && !enable));

  assert_lock_bases_R11: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> ($stable(base_cnt) && $stable(base_paddr) && $stable(base_maddr)));

  assert_tc_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tc_set |=> tc_flag);

endmodule

// File: rtl/dma_chan_addr_gen.sv
module dma_chan_addr_gen
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  input  item_size_e        size,
  output logic [ADDR_W-1:0] cur
);

  localparam int PAD_W = ADDR_W - 3;

  logic [ADDR_W-1:0] stride;
  assign stride = {{PAD_W{1'b0}}, size_bytes(size)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cur <= '0;
    else if (load) cur <= base;
    else if (step) cur <= cur + stride;
  end

  assert_hold_without_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(cur));

endmodule

// File: rtl/dma_chan_xfer_fsm.sv
module dma_chan_xfer_fsm
  import dma_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              start,
  input  logic              m2m,
  input  logic              circ,
  input  logic              dreq,
  input  logic [CNT_W-1:0]  base_cnt,
  input  item_size_e        src_size,
  input  item_size_e        dst_size,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  input  logic              rd_resp_valid,
  output logic              rd_resp_ready,
  input  logic [DATA_W-1:0] rd_resp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              item_done,
  output logic              tc_set,
  output logic              blk_end,
  output logic              reload,
  output logic [CNT_W-1:0]  cnt
);

  xfer_state_e state_q, state_d;
  logic trig, last_item, go;

  assign trig      = m2m || dreq;
  assign last_item = (cnt == CNT_W'(1));
  assign go        = enable && (cnt != '0) && trig;

  assign rd_req_valid  = (state_q == ST_RD_REQ);
  assign rd_resp_ready = (state_q == ST_RD_RESP);
  assign wr_valid      = (state_q == ST_WR);
  assign busy          = (state_q != ST_IDLE);
  assign item_done     = wr_valid && wr_ready;
  assign tc_set        = item_done && last_item;
  assign reload        = tc_set && circ;
  assign blk_end       = tc_set && !circ;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (go)            state_d = ST_RD_REQ;
      ST_RD_REQ:  if (rd_req_ready)  state_d = ST_RD_RESP;
      ST_RD_RESP: if (rd_resp_valid) state_d = ST_WR;
      ST_WR:      if (wr_ready)      state_d = ST_IDLE;
      default:                       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt     <= '0;
      wr_data <= '0;
    end else begin
      state_q <= state_d;
      if (start || reload) cnt <= base_cnt;
      else if (item_done)  cnt <= cnt - CNT_W'(1);
      if (rd_resp_valid && rd_resp_ready)
        wr_data <= size_mask(size_mask(rd_resp_data, src_size), dst_size);
    end
  end

  assert_rd_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> rd_req_valid);

  assert_wr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));

  assert_zero_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cnt == '0 && !start) |=> !rd_req_valid);

  assert_disabled_no_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !enable) |=> !rd_req_valid);

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              dreq,
  output logic              dreq_ack,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  output logic [1:0]        rd_req_size,
  input  logic              rd_resp_valid,
  output logic              rd_resp_ready,
  input  logic [31:0]       rd_resp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [1:0]        wr_size,
  output logic [31:0]       wr_data,
  output logic              ch_enabled,
  output logic              tc_flag,
  output logic              cfg_err,
  output logic [CNT_W-1:0]  remaining
);

  chan_cfg_t         cfg;
  logic              enable, start, busy, item_done, tc_set, blk_end, reload;
  logic [CNT_W-1:0]  base_cnt;
  logic [ADDR_W-1:0] base_paddr, base_maddr;
  logic [ADDR_W-1:0] side_base [N_SIDES];
  logic [ADDR_W-1:0] side_cur  [N_SIDES];
  logic              side_inc  [N_SIDES];
  item_size_e        side_size [N_SIDES];
  int unsigned       src_idx, dst_idx;
  item_size_e        src_size, dst_size;

  dma_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .busy       (busy),
    .tc_set     (tc_set),
    .blk_end    (blk_end),
    .cfg        (cfg),
    .enable     (enable),
    .start      (start),
    .base_cnt   (base_cnt),
    .base_paddr (base_paddr),
    .base_maddr (base_maddr),
    .tc_flag    (tc_flag),
    .cfg_err    (cfg_err)
  );

  assign side_base[SIDE_PER] = base_paddr;
  assign side_base[SIDE_MEM] = base_maddr;
  assign side_inc[SIDE_PER]  = cfg.pinc;
  assign side_inc[SIDE_MEM]  = cfg.minc;
  assign side_size[SIDE_PER] = cfg.psize;
  assign side_size[SIDE_MEM] = cfg.msize;

  for (genvar g = 0; g < N_SIDES; g++) begin : g_side
    dma_chan_addr_gen #(.ADDR_W(ADDR_W)) i_addr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start || reload),
      .step  (item_done && side_inc[g]),
      .base  (side_base[g]),
      .size  (side_size[g]),
      .cur   (side_cur[g])
    );
  end

  assign src_idx  = cfg.dir ? SIDE_MEM : SIDE_PER;
  assign dst_idx  = cfg.dir ? SIDE_PER : SIDE_MEM;
  assign src_size = side_size[src_idx];
  assign dst_size = side_size[dst_idx];

  dma_chan_xfer_fsm #(.CNT_W(CNT_W)) i_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .start         (start),
    .m2m           (cfg.m2m),
    .circ          (cfg.circ),
    .dreq          (dreq),
    .base_cnt      (base_cnt),
    .src_size      (src_size),
    .dst_size      (dst_size),
    .rd_req_valid  (rd_req_valid),
    .rd_req_ready  (rd_req_ready),
    .rd_resp_valid (rd_resp_valid),
    .rd_resp_ready (rd_resp_ready),
    .rd_resp_data  (rd_resp_data),
    .wr_valid      (wr_valid),
    .wr_ready      (wr_ready),
    .wr_data       (wr_data),
    .busy          (busy),
    .item_done     (item_done),
    .tc_set        (tc_set),
    .blk_end       (blk_end),
    .reload        (reload),
    .cnt           (remaining)
  );

  assign rd_req_addr = side_cur[src_idx];
  assign rd_req_size = src_size;
  assign wr_addr     = side_cur[dst_idx];
  assign wr_size     = dst_size;
  assign dreq_ack    = item_done && !cfg.m2m;
  assign ch_enabled  = enable;

  assert_circ_addr_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (rd_req_addr == $past(side_base[src_idx]) && wr_addr == $past(side_base[dst_idx])));

  assert_circ_stays_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && ch_enabled) |=> ch_enabled);

  assert_m2m_end_disables_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_set && !cfg.circ) |=> !ch_enabled);

  assert_rd_addr_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> $stable(rd_req_addr));

endmodule

// File: tb/test_dma_chan_engine.sv
module test_dma_chan_engine;
  import dma_chan_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic          dreq = 1'b0;
  logic          dreq_ack;
  logic          rd_req_valid;
  logic          rd_req_ready = 1'b0;
  logic [AW-1:0] rd_req_addr;
  logic [1:0]    rd_req_size;
  logic          rd_resp_valid = 1'b0;
  logic          rd_resp_ready;
  logic [31:0]   rd_resp_data = '0;
  logic          wr_valid;
  logic          wr_ready = 1'b0;
  logic [AW-1:0] wr_addr;
  logic [1:0]    wr_size;
  logic [31:0]   wr_data;
  logic          ch_enabled, tc_flag, cfg_err;
  logic [CW-1:0] remaining;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_engine #(.ADDR_W(AW), .CNT_W(CW)) i_dma_chan_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .dreq(dreq), .dreq_ack(dreq_ack),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_req_size(rd_req_size), .rd_resp_valid(rd_resp_valid), .rd_resp_ready(rd_resp_ready),
    .rd_resp_data(rd_resp_data), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_size(wr_size), .wr_data(wr_data), .ch_enabled(ch_enabled), .tc_flag(tc_flag),
    .cfg_err(cfg_err), .remaining(remaining)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // reference model state
  bit          m_en, m_tc, m_err, m_busy;
  bit          m_dir, m_circ, m_m2m, m_pinc, m_minc;
  logic [1:0]  m_psz, m_msz;
  int          m_rem;
  logic [15:0] m_bcnt;
  logic [31:0] m_bp, m_bm, m_cp, m_cm;
  int          items, rdreqs, req_budget, cyc;
  bit          stall, rsp_pend;
  logic [31:0] rsp_data, last_wr_addr, last_rd_addr;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int nbytes(logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
  endfunction

  function automatic logic [31:0] cut(logic [31:0] d, logic [1:0] s);
    return (s == 2'b00) ? (d & 32'hFF) : (s == 2'b01) ? (d & 32'hFFFF) : d;
  endfunction

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'hC0FFEE11;
  endfunction

  // control word layout of R13
  function automatic logic [31:0] ctrl_word(bit en, bit dir, bit circ, bit m2m,
                                            logic [1:0] psz, logic [1:0] msz, bit pinc, bit minc);
    logic [31:0] w;
    w = '0;
    w[0] = en; w[1] = dir; w[2] = circ; w[3] = m2m;
    w[5:4] = psz; w[7:6] = msz; w[8] = pinc; w[9] = minc;
    return w;
  endfunction

  task automatic model_step();
    logic [31:0] src_cur, dst_cur, w;
    logic [1:0]  ssz, dsz;
    bit          locked, done;
    src_cur = m_dir ? m_cm : m_cp;
    dst_cur = m_dir ? m_cp : m_cm;
    ssz     = m_dir ? m_msz : m_psz;
    dsz     = m_dir ? m_psz : m_msz;
    chk(ch_enabled == m_en, "R6 R10 R11 enable", 32'(ch_enabled), 32'(m_en));
    chk(tc_flag == m_tc, "R6 R7 complete flag", 32'(tc_flag), 32'(m_tc));
    chk(cfg_err == m_err, "R8 error flag", 32'(cfg_err), 32'(m_err));
    chk(remaining == 16'(m_rem), "R7 R13 remaining", 32'(remaining), 32'(m_rem));
    if (rd_req_valid && !m_busy) begin
      chk(m_en && m_rem != 0 && (m_m2m || dreq), "R5 R9 R10 item start", 32'(m_en), 32'd1);
      m_busy = 1'b1;
      rdreqs++;
    end
    if (rd_req_valid) begin
      chk(rd_req_addr == src_cur, "R1 R2 R3 read address", rd_req_addr, src_cur);
      chk(rd_req_size == ssz, "R1 R2 read size", 32'(rd_req_size), 32'(ssz));
      last_rd_addr = rd_req_addr;
    end
    chk(!rd_resp_ready || (m_busy && !rd_req_valid && !wr_valid), "R12 response ready",
        32'(rd_resp_ready), 32'd0);
    done = wr_valid && wr_ready;
    if (wr_valid) begin
      chk(wr_addr == dst_cur, "R1 R2 R3 write address", wr_addr, dst_cur);
      chk(wr_size == dsz, "R1 R2 write size", 32'(wr_size), 32'(dsz));
      chk(wr_data == cut(cut(mem_word(src_cur), ssz), dsz), "R4 write data", wr_data,
          cut(cut(mem_word(src_cur), ssz), dsz));
    end
    chk(dreq_ack == (done && !m_m2m), "R5 acknowledge", 32'(dreq_ack), 32'(done && !m_m2m));
    if (rd_req_valid && rd_req_ready) begin
      rsp_pend = 1'b1;
      rsp_data = mem_word(rd_req_addr);
    end
    if (rd_resp_valid && rd_resp_ready) rsp_pend = 1'b0;
    if (reg_we) begin
      locked = m_en || m_busy;
      w = reg_wdata;
      if (reg_addr == 2'd0) begin
        if (w[31]) m_tc = 1'b0;
        if (w[30]) m_err = 1'b0;
        if (!locked) begin
          m_dir = w[1]; m_circ = w[2]; m_m2m = w[3];
          m_psz = w[5:4]; m_msz = w[7:6]; m_pinc = w[8]; m_minc = w[9];
          if (w[0]) begin
            if (w[2] && w[3]) m_err = 1'b1;
            else begin
              m_en = 1'b1; m_rem = int'(m_bcnt); m_cp = m_bp; m_cm = m_bm;
            end
          end
        end else if (!w[0]) m_en = 1'b0;
      end else if (!locked) begin
        if (reg_addr == 2'd1) m_bcnt = w[15:0];
        if (reg_addr == 2'd2) m_bp = w;
        if (reg_addr == 2'd3) m_bm = w;
      end
    end
    if (done) begin
      items++;
      last_wr_addr = wr_addr;
      m_busy = 1'b0;
      if (m_pinc) m_cp = m_cp + 32'(nbytes(m_psz));
      if (m_minc) m_cm = m_cm + 32'(nbytes(m_msz));
      m_rem--;
      if (m_rem == 0) begin
        m_tc = 1'b1;
        if (m_circ) begin
          m_rem = int'(m_bcnt); m_cp = m_bp; m_cm = m_bm;
        end else m_en = 1'b0;
      end
      if (!m_m2m && req_budget > 0) req_budget--;
    end
    dreq = (req_budget > 0);
  endtask

  // bus slave and per-clock comparison
  initial begin
    forever begin
      @(negedge clk);
      #2;
      cyc++;
      rd_req_ready  = !stall || (cyc % 3 != 1);
      rd_resp_valid = rsp_pend && (!stall || (cyc % 4 != 2));
      rd_resp_data  = rsp_data;
      wr_ready      = !stall || (cyc % 5 != 3);
      #2;
      if (rst_n) model_step();
    end
  end

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_items(input int target);
    while (items < target) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int i0, r0;
    idle(3);
    // R13: reset state
    chk(!ch_enabled && !tc_flag && !cfg_err && remaining == 0 && !rd_req_valid && !wr_valid,
        "R13 reset state", {ch_enabled, tc_flag, cfg_err, rd_req_valid, wr_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R1 R4 R6: memory to peripheral, 32-bit source truncated to 8-bit fixed destination
    reg_write(2'd1, 32'd4);
    reg_write(2'd2, 32'h2000);
    reg_write(2'd3, 32'h1000);
    i0 = items;
    reg_write(2'd0, ctrl_word(1, 1, 0, 1, 2'b00, 2'b10, 0, 1));
    wait_items(i0 + 4);
    idle(3);
    chk(items - i0 == 4, "R6 item count", 32'(items - i0), 32'd4);
    chk(!ch_enabled && tc_flag && remaining == 0, "R6 block end", {ch_enabled, tc_flag}, 32'b01);
    chk(last_wr_addr == 32'h2000 && last_rd_addr == 32'h100C, "R1 R3 last addresses",
        last_wr_addr, 32'h2000);
    reg_write(2'd0, 32'h8000_0000);
    chk(tc_flag == 1'b0, "R11 complete flag clear", 32'(tc_flag), 32'd0);

    // R2 R3 R5: peripheral 16-bit to memory 32-bit, request paced
    reg_write(2'd1, 32'd3);
    reg_write(2'd2, 32'h3000);
    reg_write(2'd3, 32'h4000);
    i0 = items; r0 = rdreqs;
    reg_write(2'd0, ctrl_word(1, 0, 0, 0, 2'b01, 2'b10, 1, 1));
    idle(10);
    chk(rdreqs == r0, "R5 no request no item", 32'(rdreqs - r0), 32'd0);
    req_budget = 3;
    wait_items(i0 + 3);
    idle(5);
    chk(items - i0 == 3 && !ch_enabled && tc_flag, "R5 one item per request",
        32'(items - i0), 32'd3);
    chk(last_rd_addr == 32'h3004 && last_wr_addr == 32'h4008, "R2 R3 last addresses",
        last_rd_addr, 32'h3004);
    reg_write(2'd0, 32'h8000_0000);

    // R7 R11 R12: circular, 8-bit memory to reserved-size peripheral, with stalls
    stall = 1'b1;
    reg_write(2'd1, 32'd2);
    reg_write(2'd2, 32'h6000);
    reg_write(2'd3, 32'h5000);
    i0 = items;
    reg_write(2'd0, ctrl_word(1, 1, 1, 0, 2'b11, 2'b00, 1, 1));
    req_budget = 5;
    reg_write(2'd1, 32'd7);
    reg_write(2'd3, 32'h9999);
    reg_write(2'd0, ctrl_word(1, 0, 1, 0, 2'b00, 2'b00, 0, 0));
    wait_items(i0 + 5);
    idle(5);
    chk(ch_enabled && tc_flag, "R7 still enabled after reload", {ch_enabled, tc_flag}, 32'b11);
    chk(remaining == 16'd1, "R7 count reloaded", 32'(remaining), 32'd1);
    chk(last_wr_addr == 32'h6000 && last_rd_addr == 32'h5000, "R7 R11 addresses reloaded",
        last_wr_addr, 32'h6000);
    reg_write(2'd0, 32'h8000_0000);
    chk(!ch_enabled && !tc_flag, "R11 disable and clear while locked", {ch_enabled, tc_flag}, 32'd0);

    // R8: circular together with memory-to-memory
    r0 = rdreqs;
    reg_write(2'd0, ctrl_word(1, 1, 1, 1, 2'b10, 2'b10, 1, 1));
    idle(10);
    chk(cfg_err && !ch_enabled && rdreqs == r0, "R8 refused start", {cfg_err, ch_enabled}, 32'b10);
    reg_write(2'd0, 32'h4000_0000);
    chk(!cfg_err, "R11 error flag clear", 32'(cfg_err), 32'd0);

    // R9: zero count
    reg_write(2'd1, 32'd0);
    r0 = rdreqs;
    reg_write(2'd0, ctrl_word(1, 1, 0, 1, 2'b10, 2'b10, 1, 1));
    idle(20);
    chk(ch_enabled && rdreqs == r0, "R9 no bus activity", 32'(rdreqs - r0), 32'd0);
    reg_write(2'd0, 32'd0);

    // R10: disable during a block
    reg_write(2'd1, 32'd10);
    reg_write(2'd2, 32'h7000);
    reg_write(2'd3, 32'h8000);
    i0 = items; r0 = rdreqs;
    reg_write(2'd0, ctrl_word(1, 0, 0, 1, 2'b10, 2'b01, 1, 1));
    idle(7);
    reg_write(2'd0, 32'd0);
    idle(30);
    chk(!ch_enabled && !m_busy && items - i0 < 10 && items > i0, "R10 stops after item",
        32'(items - i0), 32'd1);
    chk(rdreqs - r0 == items - i0, "R10 started items completed", 32'(rdreqs - r0),
        32'(items - i0));

    finish_run();
  end

endmodule